// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

This block is a 24-line general-purpose I/O bank. It sits behind a byte-wide register interface, such as the one an I2C slave front end presents. Each 24-bit control is split into three byte registers. The most significant byte is at the lowest address, so pin n lives at group base + 2 - (n / 8).

Software controls the bank through a small set of registers:

- A direction mask turns each line into an output.
- Output levels change through separate write-one-to-set and write-one-to-clear groups.
- A monitor group returns the synchronised level of every line.

Inputs pass through a two-flop synchroniser, and a third flop holds the previous sample. A change between successive synchronised samples is an edge. An edge of an enabled polarity sets a sticky edge-status bit and a sticky interrupt-status bit. The interrupt-status bits, masked by per-pin enables, are ORed into one request line.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register is 0, so pin_oe, pin_out and gpio_irq are 0 and every status byte reads 0.
- R2: Group base addresses are: set 0x83, clear 0x86, direction 0x89, edge status 0x8C, rising enable 0x8F, falling enable 0x92, pull-up 0x95, pull-down 0x98, monitor 0xA2, interrupt enable 0x16, interrupt status 0x19. Within a group, base+0 holds pins 23..16, base+1 holds pins 15..8 and base+2 holds pins 7..0.
- R3: Writing 1 to a bit of the set group drives that pin_out bit high, and writing 1 to a bit of the clear group drives it low. Zero bits leave the output unchanged. Both groups read back the output latch.
- R4: A direction bit of 1 raises that pin_oe bit, and 0 lowers it. pin_out and pin_oe change only on a register write.
- R5: The monitor group returns the pin levels after the two-flop synchroniser, whatever their direction. A pin change driven before clock edge k reads back after edge k+1. Writes to the monitor group are ignored.
- R6: A pin records an edge only if the polarity of that edge is enabled for the pin. A 0-to-1 change needs the rising enable, and a 1-to-0 change needs the falling enable. With both enabled, both edges are recorded. The status bit is visible after edge k+2 for a pin change driven before edge k.
- R7: Edge-status and interrupt-status bits are sticky. Writing 1 to a bit clears it, and writing 0 has no effect. If a new event and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: An edge event sets the interrupt-status bit whatever the enable. gpio_irq is the OR over pins of interrupt status AND interrupt enable. Reading any register does not clear gpio_irq.
- R9: The direction, pull-up, pull-down, rising, falling and interrupt-enable groups are plain read/write storage.
- R10: Addresses outside the listed groups read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 24 | Asynchronous pin levels |
| pin_out | output | 24 | Output drive values |
| pin_oe | output | 24 | Output enables (1 = drive) |
| gpio_irq | output | 1 | Aggregated GPIO interrupt request |

## Verification
A register write is applied at the clock edge that follows the strobe, so the bench checks pin_out, pin_oe and read-back data in the low phase after that edge.

Pin levels take different times to appear:

- A pin level appears at the monitor after two edges.
- The edge and interrupt status, and gpio_irq, appear after three edges.

The bench changes pins on a falling clock edge and reads the monitor one low phase after the second rising edge. At that same moment it checks that the status is still clear, then checks the status one cycle later. The collision case schedules a clear write onto the exact edge where the event is latched.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [23:0] pin_in,
  output logic [23:0] pin_out,
  output logic [23:0] pin_oe,
  output logic        gpio_irq
);
  localparam logic [7:0] A_SET  = 8'h83;
  localparam logic [7:0] A_CLR  = 8'h86;
  localparam logic [7:0] A_DIR  = 8'h89;
  localparam logic [7:0] A_EDGE = 8'h8C;
  localparam logic [7:0] A_RISE = 8'h8F;
  localparam logic [7:0] A_FALL = 8'h92;
  localparam logic [7:0] A_PU   = 8'h95;
  localparam logic [7:0] A_PD   = 8'h98;
  localparam logic [7:0] A_MON  = 8'hA2;
  localparam logic [7:0] A_IEN  = 8'h16;
  localparam logic [7:0] A_IST  = 8'h19;

  function automatic logic [23:0] lane_sel(input logic [7:0] a, input logic [7:0] base);
    if (a == base)              return 24'hFF0000;
    else if (a == base + 8'd1)  return 24'h00FF00;
    else if (a == base + 8'd2)  return 24'h0000FF;
    else                        return 24'h000000;
  endfunction

  function automatic logic [7:0] pick(input logic [23:0] v, input logic [23:0] sel);
    return (v[23:16] & sel[23:16]) | (v[15:8] & sel[15:8]) | (v[7:0] & sel[7:0]);
  endfunction

  logic [23:0] out_q, dir_q, rise_q, fall_q, pu_q, pd_q, ien_q, edge_q, ist_q;
  logic [23:0] s1, s2, s3;

  logic [23:0] wide;
  assign wide = {3{reg_wdata}};

  logic [23:0] m_set, m_clr, m_dir, m_edge, m_rise, m_fall, m_pu, m_pd, m_ien, m_ist;
  assign m_set  = reg_we ? lane_sel(reg_addr, A_SET)  : '0;
  assign m_clr  = reg_we ? lane_sel(reg_addr, A_CLR)  : '0;
  assign m_dir  = reg_we ? lane_sel(reg_addr, A_DIR)  : '0;
  assign m_edge = reg_we ? lane_sel(reg_addr, A_EDGE) : '0;
  assign m_rise = reg_we ? lane_sel(reg_addr, A_RISE) : '0;
  assign m_fall = reg_we ? lane_sel(reg_addr, A_FALL) : '0;
  assign m_pu   = reg_we ? lane_sel(reg_addr, A_PU)   : '0;
  assign m_pd   = reg_we ? lane_sel(reg_addr, A_PD)   : '0;
  assign m_ien  = reg_we ? lane_sel(reg_addr, A_IEN)  : '0;
  assign m_ist  = reg_we ? lane_sel(reg_addr, A_IST)  : '0;

  logic [23:0] ev;
  assign ev = (s2 & ~s3 & rise_q) | (~s2 & s3 & fall_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      out_q <= '0; dir_q <= '0; rise_q <= '0; fall_q <= '0;
      pu_q <= '0; pd_q <= '0; ien_q <= '0; edge_q <= '0; ist_q <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      out_q  <= (out_q | (wide & m_set)) & ~(wide & m_clr);
      dir_q  <= (dir_q  & ~m_dir)  | (wide & m_dir);
      rise_q <= (rise_q & ~m_rise) | (wide & m_rise);
      fall_q <= (fall_q & ~m_fall) | (wide & m_fall);
      pu_q   <= (pu_q   & ~m_pu)   | (wide & m_pu);
      pd_q   <= (pd_q   & ~m_pd)   | (wide & m_pd);
      ien_q  <= (ien_q  & ~m_ien)  | (wide & m_ien);
      edge_q <= (edge_q & ~(wide & m_edge)) | ev;
      ist_q  <= (ist_q  & ~(wide & m_ist))  | ev;
    end
  end

  assign reg_rdata = pick(out_q,  lane_sel(reg_addr, A_SET))
                   | pick(out_q,  lane_sel(reg_addr, A_CLR))
                   | pick(dir_q,  lane_sel(reg_addr, A_DIR))
                   | pick(edge_q, lane_sel(reg_addr, A_EDGE))
                   | pick(rise_q, lane_sel(reg_addr, A_RISE))
                   | pick(fall_q, lane_sel(reg_addr, A_FALL))
                   | pick(pu_q,   lane_sel(reg_addr, A_PU))
                   | pick(pd_q,   lane_sel(reg_addr, A_PD))
                   | pick(s2,     lane_sel(reg_addr, A_MON))
                   | pick(ien_q,  lane_sel(reg_addr, A_IEN))
                   | pick(ist_q,  lane_sel(reg_addr, A_IST));

  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign gpio_irq = |(ist_q & ien_q);
endmodule

module gpio_edge_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic [23:0] pin_out,
  input logic [23:0] pin_oe,
  input logic        gpio_irq
);
  // R3
  set_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h85) |=> ((pin_out[7:0] & $past(reg_wdata)) == $past(reg_wdata)));
  // R3
  clr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 8'h88) |=> ((pin_out[7:0] & $past(reg_wdata)) == 8'h00));
  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(pin_out));
  // R4
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(pin_oe));
  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio_irq && !reg_we) |=> gpio_irq);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk u_chk (.*);

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/1ps
module tb_gpio_edge_bank;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic [23:0] pin_in = 0, pin_out, pin_oe;
  logic gpio_irq;
  int tests = 0, fails = 0;
  bit done = 0;

  gpio_edge_bank dut (.*);

  always #2.5 clk = ~clk;

  logic [23:0] m_out, m_dir, m_rise, m_fall, m_pu, m_pd, m_ien;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic bit in_grp(input logic [7:0] a, input logic [7:0] base);
    return a >= base && a <= base + 8'd2;
  endfunction

  function automatic int shamt(input logic [7:0] a, input logic [7:0] base);
    return 8 * (2 - int'(a - base));
  endfunction

  function automatic logic [7:0] byte_of(input logic [23:0] v, input logic [7:0] a, input logic [7:0] base);
    logic [23:0] t;
    t = v >> shamt(a, base);
    return t[7:0];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (in_grp(a, 8'h83)) return byte_of(m_out, a, 8'h83);
    if (in_grp(a, 8'h86)) return byte_of(m_out, a, 8'h86);
    if (in_grp(a, 8'h89)) return byte_of(m_dir, a, 8'h89);
    if (in_grp(a, 8'h8F)) return byte_of(m_rise, a, 8'h8F);
    if (in_grp(a, 8'h92)) return byte_of(m_fall, a, 8'h92);
    if (in_grp(a, 8'h95)) return byte_of(m_pu, a, 8'h95);
    if (in_grp(a, 8'h98)) return byte_of(m_pd, a, 8'h98);
    if (in_grp(a, 8'h16)) return byte_of(m_ien, a, 8'h16);
    if (in_grp(a, 8'hA2)) return byte_of(pin_in, a, 8'hA2);
    return 8'h00;
  endfunction

  function automatic logic [23:0] put(input logic [23:0] v, input logic [7:0] a, input logic [7:0] base, input logic [7:0] d);
    logic [23:0] m, x;
    m = 24'hFF << shamt(a, base);
    x = {16'h0, d} << shamt(a, base);
    return (v & ~m) | x;
  endfunction

  task automatic mdl_wr(input logic [7:0] a, input logic [7:0] d);
    if (in_grp(a, 8'h83)) m_out = m_out | ({16'h0, d} << shamt(a, 8'h83));
    if (in_grp(a, 8'h86)) m_out = m_out & ~({16'h0, d} << shamt(a, 8'h86));
    if (in_grp(a, 8'h89)) m_dir  = put(m_dir, a, 8'h89, d);
    if (in_grp(a, 8'h8F)) m_rise = put(m_rise, a, 8'h8F, d);
    if (in_grp(a, 8'h92)) m_fall = put(m_fall, a, 8'h92, d);
    if (in_grp(a, 8'h95)) m_pu   = put(m_pu, a, 8'h95, d);
    if (in_grp(a, 8'h98)) m_pd   = put(m_pd, a, 8'h98, d);
    if (in_grp(a, 8'h16)) m_ien  = put(m_ien, a, 8'h16, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    mdl_wr(a, d);
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_out = 0; m_dir = 0; m_rise = 0; m_fall = 0; m_pu = 0; m_pd = 0; m_ien = 0;
  endtask

  task automatic pin_step(input logic [23:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: run hung, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, a;
    logic [7:0] grp [8];
    string tag;
    void'($urandom(32'd2024));
    grp = '{8'h83, 8'h86, 8'h89, 8'h8F, 8'h92, 8'h95, 8'h98, 8'h16};

    pin_in = 24'h000000;
    do_reset();
    peek(8'h8B, d); chk("R1 dir reset", d, 0);
    peek(8'h8E, d); chk("R1 edge reset", d, 0);
    peek(8'h1B, d); chk("R1 ist reset", d, 0);
    chk("R1 pin_oe reset", pin_oe, 0);
    chk("R1 pin_out reset", pin_out, 0);
    chk("R1 irq reset", gpio_irq, 0);

    pin_in = 24'h5A3C96;
    repeat (5) @(negedge clk);
    peek(8'hA2, d); chk("R5 monitor msb", d, 8'h5A);
    peek(8'hA4, d); chk("R5 monitor lsb", d, 8'h96);

    wr(8'h85, 8'hFF); wr(8'h88, 8'h0F);
    chk("R3 set then clear", pin_out, 24'h0000F0);
    wr(8'h85, 8'h00);
    chk("R3 set zero no effect", pin_out, 24'h0000F0);
    wr(8'h83, 8'h81);
    chk("R3 set msb lane", pin_out, 24'h8100F0);
    wr(8'h89, 8'hC3);
    chk("R4 direction msb", pin_oe, 24'hC30000);
    wr(8'h96, 8'hA5);
    peek(8'h96, d); chk("R9 pull-up storage", d, 8'hA5);

    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 10;
      if (r == 0) begin
        a = 8'h20 + 8'($urandom % 64);
        tag = "R10 unmapped";
      end else if (r == 1) begin
        a = 8'hA2 + 8'($urandom % 3);
        tag = "R5 monitor write";
      end else begin
        int g;
        g = $urandom % 8;
        a = grp[g] + 8'($urandom % 3);
        tag = (g < 2) ? "R3 set/clear" : (g == 2) ? "R4 dir" :
              (g >= 5 && g <= 6) ? "R9 pull" : "R2 storage";
      end
      d = 8'($urandom);
      wr(a, d);
      chk({tag, " pin_out"}, pin_out, m_out);
      chk({tag, " pin_oe"}, pin_oe, m_dir);
      peek(a, d); chk({tag, " readback"}, d, exp_rd(a));
      a = 8'($urandom);
      peek(a, d); chk("R10 random read", d, exp_rd(a));
      chk("R6 no edge on static pins", gpio_irq, 0);
    end

    pin_in = 0;
    do_reset();
    chk("R1 second reset oe", pin_oe, 0);
    repeat (4) @(negedge clk);
    wr(8'h91, 8'h05);
    wr(8'h94, 8'h06);
    wr(8'h18, 8'h03);

    pin_step(24'h000001);
    peek(8'hA4, d); chk("R5 monitor after two edges", d, 8'h01);
    peek(8'h8E, d); chk("R6 status not before third edge", d, 8'h00);
    @(negedge clk);
    peek(8'h8E, d); chk("R6 rise recorded", d, 8'h01);
    peek(8'h1B, d); chk("R8 ist set", d, 8'h01);
    chk("R8 irq raised", gpio_irq, 1);

    pin_step(24'h000000); @(negedge clk);
    peek(8'h8E, d); chk("R6 fall ignored when disabled", d, 8'h01);
    wr(8'h8E, 8'h00);
    peek(8'h8E, d); chk("R7 write zero keeps", d, 8'h01);
    wr(8'h8E, 8'h01);
    peek(8'h8E, d); chk("R7 w1c edge", d, 8'h00);
    peek(8'h1B, d); peek(8'h1B, d);
    chk("R8 read does not clear irq", gpio_irq, 1);
    wr(8'h1B, 8'h01);
    chk("R7 w1c ist drops irq", gpio_irq, 0);

    pin_step(24'h000002); @(negedge clk);
    peek(8'h8E, d); chk("R6 rise ignored when only fall", d, 8'h00);
    pin_step(24'h000000); @(negedge clk);
    peek(8'h8E, d); chk("R6 fall recorded", d, 8'h02);
    chk("R8 irq from pin1", gpio_irq, 1);
    wr(8'h8E, 8'h02); wr(8'h1B, 8'h02);

    pin_step(24'h000004); @(negedge clk);
    peek(8'h8E, d); chk("R6 both: rise", d, 8'h04);
    peek(8'h1B, d); chk("R8 ist set without enable", d, 8'h04);
    chk("R8 irq masked", gpio_irq, 0);
    wr(8'h8E, 8'h04);
    pin_step(24'h000000); @(negedge clk);
    peek(8'h8E, d); chk("R6 both: fall", d, 8'h04);
    wr(8'h8E, 8'h04); wr(8'h1B, 8'h04);

    wr(8'h8F, 8'h10); wr(8'h16, 8'h10);
    pin_step(24'h100000); @(negedge clk);
    peek(8'h8C, d); chk("R2 pin20 in msb byte", d, 8'h10);
    peek(8'h8E, d); chk("R2 lsb byte clear", d, 8'h00);
    chk("R2 irq pin20", gpio_irq, 1);
    wr(8'h8C, 8'h10); wr(8'h19, 8'h10);
    chk("R7 irq cleared pin20", gpio_irq, 0);

    @(negedge clk);
    pin_in = 24'h100001;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 8'h8E; reg_wdata = 8'h01; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
    peek(8'h8E, d); chk("R7 event wins over clear", d, 8'h01);
    wr(8'h8E, 8'h01);
    peek(8'h8E, d); chk("R7 clear after collision", d, 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule